// File: doc/BRIEF.md
# Programmable Waveform Sequencer Engine

This block is a small micro-sequencer that drives a sampling interface from a table of per-state descriptor bytes rather than from fixed logic. A 128-byte descriptor memory holds four waveform programs. Each program describes seven active states, S0 to S6. State 7 is the idle state. A start strobe carries a transaction type, and a select register maps that type to one of the four programs. The engine then walks the states until one of them leads to state 7.

A state is either a timed state or a decision state. A timed state holds for a programmed number of clock cycles and can push the sampled data bus into a downstream FIFO. A decision state combines two selected flags with a programmed logic function. It branches to one of two target states. The FIFO full flag is one of the selectable terms, so a program can keep sampling until the FIFO fills. An abort input forces the engine back to idle at any time. Two configuration registers set what the control outputs and the data bus driver do while the engine is idle.

Top module: `wseq_engine`

## Requirements
- R1: After reset the engine is idle, `busy` and `fifo_we` are 0, and `ctl_out` is 0. `data_oe` is 0 because the idle-control register resets to 0x01. The select register resets to 0xE4, which maps transaction type t to program t.
- R2: Descriptor byte address = program*32 + section*8 + state. The sections are 0 length/branch, 1 opcode, 2 output and 3 logic. Slot 7 of each section is not used.
- R3: With the engine idle, a `start` sampled at a clock edge enters S0 at that edge. The program is chosen by select-register bits [2t+1:2t], where t is `start_type`. The types are 0 FIFO read, 1 FIFO write, 2 single read and 3 single write. `cfg_addr` 0 writes the select register.
- R4: A timed state stays for L cycles, where L is its length byte, and then moves to the next state. L=0 means 256 cycles. Leaving S6 returns to idle.
- R5: In the opcode byte, bit 0 = 1 marks a decision state and bit 1 requests a sample. A sampling timed state raises `fifo_we` in its first cycle only, with `fifo_wdata` equal to `data_in`. It does this only if `fifo_full` is 0.
- R6: A decision state decodes its branch byte as bits 5:3 = target when the condition is true and bits 2:0 = target when it is false. Without re-execute it takes one cycle. A target of 7 ends the program.
- R7: With branch-byte bit 7 (re-execute) set, a decision state holds for one reload cycle. It evaluates and branches in its second cycle.
- R8: The logic byte is decoded as bits 7:6 = function (0 A AND B, 1 A OR B, 2 A XOR B, 3 A AND NOT B), bits 5:3 = term A select and bits 2:0 = term B select. Select codes 0 to 5 pick `flags_in[code]`, code 6 picks `fifo_full` and code 7 is constant 1. So 0x36 branches true when the FIFO is full.
- R9: `abort` sampled at an edge forces idle after that edge. It takes priority over `start`.
- R10: A `start` that arrives while the engine is busy is ignored.
- R11: While busy, `ctl_out` shows the low 6 bits of the current state's output byte. While idle, it shows the idle-value register (`cfg_addr` 2).
- R12: `data_oe` is 0 while busy. While idle it is the inverse of bit 0 of the idle-control register (`cfg_addr` 1), so a set bit tri-states the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low reset |
| desc_we | input | 1 | Descriptor byte write enable |
| desc_addr | input | 7 | Descriptor byte address |
| desc_wdata | input | 8 | Descriptor byte data |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_addr | input | 2 | 0 select, 1 idle control, 2 idle value |
| cfg_wdata | input | 8 | Configuration register data |
| start | input | 1 | Start strobe |
| start_type | input | 2 | Transaction type carried by start |
| abort | input | 1 | Abort, forces idle |
| flags_in | input | FLAG_W | General flags selectable as logic terms |
| fifo_full | input | 1 | Downstream FIFO full flag |
| data_in | input | DATA_W | Sampled data bus |
| fifo_we | output | 1 | FIFO write strobe |
| fifo_wdata | output | DATA_W | FIFO write data |
| ctl_out | output | CTL_W | Control outputs |
| data_oe | output | 1 | Data bus drive enable |
| busy | output | 1 | A program is running |

## Verification
All state is registered, so each result is due a fixed number of edges after its cause. A start or an abort sampled at an edge changes `busy` right after that edge. A configuration write is visible after the edge that takes it. `fifo_we` is combinational from the current state and `fifo_full`, so it reads in the same cycle that `fifo_full` is driven.

The bench drives inputs on the falling edge and samples one time step later. It counts cycles from the start edge and compares each program's busy length, write count, first-write cycle and control-output trace with closed forms. A looping sample program of length L with the full flag raised at cycle F stays busy for (L+1)*ceil(F/(L+1)) cycles and writes ceil((F-1)/(L+1)) times.

// File: rtl/wseq_pkg.sv
package wseq_pkg;
    localparam int NWAVE      = 4;
    localparam int NSECT      = 4;
    localparam int NSLOT      = 8;
    localparam int BYTE_W     = 8;
    localparam int WAVE_W     = $clog2(NWAVE);
    localparam int SECT_W     = $clog2(NSECT);
    localparam int ST_W       = $clog2(NSLOT);
    localparam int DESC_DEPTH = NWAVE * NSECT * NSLOT;
    localparam int DESC_AW    = $clog2(DESC_DEPTH);
    localparam logic [ST_W-1:0] IDLE_ST = ST_W'(NSLOT - 1);
    localparam int FULL_CODE  = 6;
    localparam int ONE_CODE   = 7;

    typedef enum logic [1:0] {
        FN_AND  = 2'd0,
        FN_OR   = 2'd1,
        FN_XOR  = 2'd2,
        FN_ANDN = 2'd3
    } lfunc_e;

    typedef struct packed {
        logic [BYTE_W-1:0] len_br;
        logic [BYTE_W-1:0] opcode;
        logic [BYTE_W-1:0] outp;
        logic [BYTE_W-1:0] logic_fn;
    } slot_t;

    typedef struct packed {
        logic [ST_W-1:0]   st;
        logic [BYTE_W-1:0] cnt;
        logic [WAVE_W-1:0] wave;
    } seq_t;

    typedef struct packed {
        logic [BYTE_W-1:0] wsel;
        logic [BYTE_W-1:0] idle_cs;
        logic [BYTE_W-1:0] idle_val;
    } cfg_t;
endpackage

// File: rtl/wseq_desc_mem.sv
module wseq_desc_mem
    import wseq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [DESC_AW-1:0]   waddr,
    input  logic [BYTE_W-1:0]    wdata,
    input  logic [WAVE_W-1:0]    rd_wave,
    input  logic [ST_W-1:0]      rd_state,
    output slot_t                slot
);
    logic [BYTE_W-1:0] mem_q [DESC_DEPTH];
    logic [BYTE_W-1:0] mem_d [DESC_DEPTH];
    logic [BYTE_W-1:0] sect_byte [NSECT];

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DESC_DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    for (genvar s = 0; s < NSECT; s++) begin : g_sect
        assign sect_byte[s] = mem_q[{rd_wave, SECT_W'(s), rd_state}];
    end

    assign slot = '{len_br:   sect_byte[0],
                    opcode:   sect_byte[1],
                    outp:     sect_byte[2],
                    logic_fn: sect_byte[3]};
endmodule

// File: rtl/wseq_cond_eval.sv
module wseq_cond_eval
    import wseq_pkg::*;
#(
    parameter int FLAG_W = 6
) (
    input  logic [BYTE_W-1:0] logic_fn,
    input  logic [FLAG_W-1:0] flags,
    input  logic              fifo_full,
    output logic              cond
);
    logic [NSLOT-1:0] terms;
    logic             term_a;
    logic             term_b;
    lfunc_e           fn;

    for (genvar k = 0; k < NSLOT; k++) begin : g_term
        if (k == FULL_CODE) begin : g_full
            assign terms[k] = fifo_full;
        end else if (k == ONE_CODE) begin : g_one
            assign terms[k] = 1'b1;
        end else if (k < FLAG_W) begin : g_flag
            assign terms[k] = flags[k];
        end else begin : g_zero
            assign terms[k] = 1'b0;
        end
    end

    assign fn     = lfunc_e'(logic_fn[7:6]);
    assign term_a = terms[logic_fn[5:3]];
    assign term_b = terms[logic_fn[2:0]];

    always_comb begin
        unique case (fn)
            FN_AND:  cond = term_a & term_b;
            FN_OR:   cond = term_a | term_b;
            FN_XOR:  cond = term_a ^ term_b;
            FN_ANDN: cond = term_a & ~term_b;
            default: cond = 1'b0;
        endcase
    end
endmodule

// File: rtl/wseq_cfg_regs.sv
module wseq_cfg_regs
    import wseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    output cfg_t              cfg
);
    localparam logic [BYTE_W-1:0] WSEL_RST = 8'hE4;
    localparam logic [BYTE_W-1:0] IDLE_CS_RST = 8'h01;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (addr)
                2'd0:    cfg_d.wsel     = wdata;
                2'd1:    cfg_d.idle_cs  = wdata;
                2'd2:    cfg_d.idle_val = wdata;
                default: cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{wsel: WSEL_RST, idle_cs: IDLE_CS_RST, idle_val: '0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/wseq_engine.sv
module wseq_engine
    import wseq_pkg::*;
#(
    parameter int FLAG_W = 6,
    parameter int CTL_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 desc_we,
    input  logic [DESC_AW-1:0]   desc_addr,
    input  logic [BYTE_W-1:0]    desc_wdata,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_addr,
    input  logic [BYTE_W-1:0]    cfg_wdata,
    input  logic                 start,
    input  logic [WAVE_W-1:0]    start_type,
    input  logic                 abort,
    input  logic [FLAG_W-1:0]    flags_in,
    input  logic                 fifo_full,
    input  logic [DATA_W-1:0]    data_in,
    output logic                 fifo_we,
    output logic [DATA_W-1:0]    fifo_wdata,
    output logic [CTL_W-1:0]     ctl_out,
    output logic                 data_oe,
    output logic                 busy
);
    localparam logic [BYTE_W-1:0] CNT_FIRST = BYTE_W'(1);
    localparam logic [BYTE_W-1:0] CNT_RELOAD = BYTE_W'(2);

    seq_t        seq_d, seq_q;
    slot_t       slot;
    cfg_t        cfg;
    logic        cond;
    logic        is_idle;
    logic        is_dp;
    logic        do_sample;
    logic        reexec;
    logic [ST_W-1:0] target;
    logic        unused_bits;

    wseq_desc_mem u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (desc_we),
        .waddr    (desc_addr),
        .wdata    (desc_wdata),
        .rd_wave  (seq_q.wave),
        .rd_state (seq_q.st),
        .slot     (slot)
    );

    wseq_cond_eval #(.FLAG_W(FLAG_W)) u_cond (
        .logic_fn  (slot.logic_fn),
        .flags     (flags_in),
        .fifo_full (fifo_full),
        .cond      (cond)
    );

    wseq_cfg_regs u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    assign is_idle   = (seq_q.st == IDLE_ST);
    assign is_dp     = slot.opcode[0];
    assign do_sample = slot.opcode[1];
    assign reexec    = slot.len_br[7];
    assign target    = cond ? slot.len_br[5:3] : slot.len_br[2:0];

    always_comb begin
        seq_d = seq_q;
        if (abort) begin
            seq_d.st  = IDLE_ST;
            seq_d.cnt = CNT_FIRST;
        end else if (is_idle) begin
            if (start) begin
                seq_d.st   = '0;
                seq_d.cnt  = CNT_FIRST;
                seq_d.wave = cfg.wsel[{start_type, 1'b0} +: WAVE_W];
            end
        end else if (is_dp) begin
            if (reexec && seq_q.cnt == CNT_FIRST) begin
                seq_d.cnt = CNT_RELOAD;
            end else begin
                seq_d.st  = target;
                seq_d.cnt = CNT_FIRST;
            end
        end else begin
            if (seq_q.cnt == slot.len_br) begin
                seq_d.st  = seq_q.st + 1'b1;
                seq_d.cnt = CNT_FIRST;
            end else begin
                seq_d.cnt = seq_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: IDLE_ST, cnt: CNT_FIRST, wave: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy       = !is_idle;
    assign fifo_we    = busy && !is_dp && do_sample && (seq_q.cnt == CNT_FIRST) && !fifo_full;
    assign fifo_wdata = data_in;
    assign ctl_out    = is_idle ? cfg.idle_val[CTL_W-1:0] : slot.outp[CTL_W-1:0];
    assign data_oe    = is_idle && !cfg.idle_cs[0];

    assign unused_bits = ^{slot.opcode, slot.outp, cfg.idle_cs, cfg.idle_val, slot.len_br[6]};

    // R3: an accepted start puts the engine in S0 one edge later
    assert_start_enters_s0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_idle && start && !abort) |=> (seq_q.st == '0 && busy));

    // R9: abort forces idle after the edge that samples it
    assert_abort_idles_R9: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !busy);

    // R10: a start while busy leaves the selected program untouched
    assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !abort) |=> $stable(seq_q.wave));

    // R4: a timed state that has not used its length stays put
    assert_timed_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !is_dp && seq_q.cnt != slot.len_br && !abort) |=> $stable(seq_q.st));

    // R7: re-execute holds the decision state for its reload cycle
    assert_reexec_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && is_dp && reexec && seq_q.cnt == CNT_FIRST && !abort) |=> $stable(seq_q.st));
endmodule

// File: tb/tb_wseq_engine.sv
module tb_wseq_engine;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       desc_we = 1'b0;
    logic [6:0] desc_addr = '0;
    logic [7:0] desc_wdata = '0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       start = 1'b0;
    logic [1:0] start_type = '0;
    logic       abort = 1'b0;
    logic [5:0] flags_in = '0;
    logic       fifo_full = 1'b0;
    logic [7:0] data_in = '0;
    logic       fifo_we;
    logic [7:0] fifo_wdata;
    logic [5:0] ctl_out;
    logic       data_oe;
    logic       busy;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int r_busy, r_we, r_first, r_dmis, r_oe;
    logic [5:0] ctl_tr [1:4];

    always #(CLK_PERIOD/2) clk = ~clk;

    wseq_engine dut (
        .clk(clk), .rst_n(rst_n),
        .desc_we(desc_we), .desc_addr(desc_addr), .desc_wdata(desc_wdata),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .start(start), .start_type(start_type), .abort(abort),
        .flags_in(flags_in), .fifo_full(fifo_full), .data_in(data_in),
        .fifo_we(fifo_we), .fifo_wdata(fifo_wdata), .ctl_out(ctl_out),
        .data_oe(data_oe), .busy(busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    task automatic wr_desc(input int w, input int sect, input int st, input int val);
        @(negedge clk);
        desc_we = 1'b1;
        desc_addr = 7'(w * 32 + sect * 8 + st);   // R2 addressing
        desc_wdata = 8'(val);
        @(posedge clk);
        @(negedge clk);
        desc_we = 1'b0;
    endtask

    task automatic prog(input int w, input int st, input int lb, input int op,
                        input int outv, input int lf);
        wr_desc(w, 0, st, lb);
        wr_desc(w, 1, st, op);
        wr_desc(w, 2, st, outv);
        wr_desc(w, 3, st, lf);
    endtask

    task automatic wr_cfg(input int a, input int v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = 2'(a);
        cfg_wdata = 8'(v);
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run(input int typ, input int full_at, input int abort_at,
                       input int restart_at);
        r_busy = 0; r_we = 0; r_first = 0; r_dmis = 0; r_oe = 0;
        for (int k = 1; k <= 4; k++) ctl_tr[k] = '0;
        @(negedge clk);
        start = 1'b1;
        start_type = 2'(typ);
        @(posedge clk);
        for (int i = 1; i < 2000; i++) begin
            @(negedge clk);
            start = (i == restart_at);
            start_type = (i == restart_at) ? 2'd0 : 2'(typ);
            abort = (i == abort_at);
            fifo_full = (i >= full_at);
            data_in = 8'($urandom);
            #1;
            if (!busy) break;
            r_busy++;
            if (i <= 4) ctl_tr[i] = ctl_out;
            if (data_oe) r_oe++;
            if (fifo_we) begin
                r_we++;
                if (r_first == 0) r_first = i;
                if (fifo_wdata != data_in) r_dmis++;
            end
        end
        start = 1'b0;
        abort = 1'b0;
        fifo_full = 1'b0;
    endtask

    function automatic int exp_loop_busy(input int l, input int f);
        int p = l + 1;
        return p * ((f + p - 1) / p);
    endfunction

    function automatic int exp_loop_we(input int l, input int f);
        int p = l + 1;
        return (f - 1 + p - 1) / p;
    endfunction

    function automatic int exp_cond(input int fn, input int a, input int b);
        case (fn)
            0: return a & b;
            1: return a | b;
            2: return a ^ b;
            default: return a & (1 - b);
        endcase
    endfunction

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 busy after reset", busy, 0);
        chk("R1 fifo_we after reset", fifo_we, 0);
        chk("R1 data_oe after reset", data_oe, 0);
        chk("R1 ctl_out after reset", ctl_out, 0);

        // program 3: timed 5 no sample, timed 1 sample, decision to 7
        prog(3, 0, 5, 0, 1, 0);
        prog(3, 1, 1, 2, 2, 0);
        prog(3, 2, 8'h3F, 1, 3, 8'hFF);
        // program 2: re-execute decision to S1, then decision to 7
        prog(2, 0, 8'h89, 1, 7, 8'hFF);
        prog(2, 1, 8'h3F, 1, 9, 8'hFF);
        // program 1: decision on flags[0], flags[1]; true S1, false S2
        prog(1, 1, 8'h3F, 1, 8'h11, 8'hFF);
        prog(1, 2, 8'h3F, 1, 8'h22, 8'hFF);
        // program 0: sampling loop until FIFO full (logic 0x36)
        prog(0, 1, 8'h38, 1, 0, 8'h36);

        // R3 R5 R6 R8: random length and full-flag timing, reset select map
        for (int it = 0; it < 6; it++) begin
            int l = 1 + int'($urandom % 4);
            int f = 2 + int'($urandom % 19);
            wr_desc(0, 0, 0, l);
            wr_desc(0, 1, 0, 2);
            run(0, f, 0, 0);
            chk("R6 loop busy length", r_busy, exp_loop_busy(l, f));
            chk("R5 loop write count", r_we, exp_loop_we(l, f));
            chk("R5 write data", r_dmis, 0);
        end

        // R9: abort mid-program
        wr_desc(0, 0, 0, 2);
        run(0, 100000, 5, 0);
        chk("R9 abort busy length", r_busy, 5);
        chk("R9 abort write count", r_we, 2);

        // R9: abort wins over start in the same cycle
        @(negedge clk);
        start = 1'b1; abort = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0; abort = 1'b0;
        #1;
        chk("R9 abort over start", busy, 0);

        // R3 R2: remap type 2 to program 3
        wr_cfg(0, 8'hB4);
        run(2, 100000, 0, 0);
        chk("R4 timed program busy", r_busy, 7);
        chk("R5 single write", r_we, 1);
        chk("R5 write in first cycle of S1", r_first, 6);

        // R7 R11: type 3 maps to program 2
        run(3, 100000, 0, 0);
        chk("R7 re-execute busy", r_busy, 3);
        chk("R11 ctl cycle 1", ctl_tr[1], 7);
        chk("R11 ctl cycle 2", ctl_tr[2], 7);
        chk("R11 ctl cycle 3", ctl_tr[3], 9);

        // R10: start while busy is ignored
        run(2, 100000, 0, 3);
        chk("R10 restart ignored busy", r_busy, 7);
        chk("R10 restart ignored writes", r_we, 1);
        chk("R12 no drive while busy", r_oe, 0);

        // R8 R6: random logic functions; type 1 maps to program 1
        for (int it = 0; it < 16; it++) begin
            int fn = int'($urandom % 4);
            int a = int'($urandom % 2);
            int b = int'($urandom % 2);
            prog(1, 0, 8'h0A, 1, 5, (fn << 6) | 1);
            flags_in = 6'({b[0], a[0]});
            run(1, 100000, 0, 0);
            chk("R8 logic branch ctl", ctl_tr[2], exp_cond(fn, a, b) ? 8'h11 : 8'h22);
            chk("R6 decision one cycle", r_busy, 2);
        end
        flags_in = '0;

        // R12 R11: idle behaviour
        wr_cfg(1, 0);
        #1;
        chk("R12 drive when idle bit clear", data_oe, 1);
        wr_cfg(2, 8'h2A);
        #1;
        chk("R11 idle value", ctl_out, 8'h2A);
        wr_cfg(1, 1);
        #1;
        chk("R12 tri-state when idle bit set", data_oe, 0);

        // R4: fall through S6 to idle
        for (int s = 0; s < 7; s++) prog(0, s, 1, 0, s, 0);
        run(0, 100000, 0, 0);
        chk("R4 S6 falls to idle", r_busy, 7);

        // R4: length 0 means 256 cycles
        prog(0, 0, 0, 0, 0, 0);
        prog(0, 1, 8'h3F, 1, 0, 8'hFF);
        run(0, 100000, 0, 0);
        chk("R4 length zero", r_busy, 257);

        finish_run();
    end
endmodule